// File: doc/BRIEF.md
# Vectored Eight-Input Interrupt Controller

This block collects eight interrupt inputs and decides which one a processor should service next. It is programmed over a byte-wide bus with one address bit. At the even address, software writes an initialization start word or an operation command. At the odd address, it writes the rest of the setup words and, once setup is done, the 8-bit mask. Each rising input edge is latched as a pending request. Masked requests are set aside. The best remaining request is compared with the levels already in service, and the interrupt output rises only when that request outranks all of them.

Software takes an interrupt in one of two ways. It can arm a poll and read the even address, or it can pulse the hardware acknowledge input and read back the 8-bit vector. Either way the request is moved from pending to in-service. If nothing valid remains when the acknowledge happens, the block answers with level 7 and leaves its in-service bit clear, so software can tell that the interrupt was spurious. A non-specific end-of-interrupt command retires the most urgent in-service level. Cascade wiring is only described by a setup word, which the block consumes and does not act on.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the mask reads back 0xFF at the odd address, the pending and in-service registers are zero, an even-address read returns the pending register, and the interrupt output is low.
- R2: A write to the even address with bit 4 set starts setup, clears the pending and in-service registers and selects the pending register for readback. The next odd-address write sets the vector base, and only its bits 7:3 are kept.
- R3: After the base word, one odd-address write is taken as the cascade word unless bit 1 of the start word was set. One further odd-address write is taken as the mode word only if bit 0 of the start word was set. Every later odd-address write loads the mask.
- R4: Once setup is complete, an odd-address write loads the mask, and an odd-address read returns it. A 1 in a mask bit disables that input.
- R5: A rising edge on an input sets its pending bit. The bit is cleared when that level is acknowledged, and an input that stays high does not set it again.
- R6: Input 0 has the highest priority and input 7 the lowest. The interrupt output is high only when an unmasked pending request has strictly higher priority than every in-service level.
- R7: Command 0x0C arms a poll. The next even-address read returns bit 7 set and the winning level in bits 2:0, sets that level's in-service bit and clears its pending bit. Later even-address reads again return the selected register.
- R8: Command 0x0A selects the pending register and command 0x0B selects the in-service register for even-address reads. The selection lasts until it is changed again.
- R9: A pulse on the hardware acknowledge input sets the winner's in-service bit and clears its pending bit. From the next cycle, the vector output holds base bits 7:3 with the level in bits 2:0.
- R10: An acknowledge with no valid winner reports level 7 and leaves the in-service register unchanged. In that case a poll read returns 0x07 and the vector holds base bits 7:3 with 7 in bits 2:0.
- R11: Command 0x20 clears the highest-priority set bit of the in-service register. Other commands with bits 4:3 clear and bits 7:5 not equal to 001 are ignored.
- R12: A masked input never raises the interrupt output and is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 1 | Register address bit (0 = command/status, 1 = setup/mask) |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRe | input | 1 | Read strobe, one cycle per read |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, valid while busRe is high |
| irqIn | input | 8 | Interrupt request inputs, rising-edge sensed |
| intAck | input | 1 | Hardware acknowledge pulse |
| intOut | output | 1 | Interrupt request to the processor |
| ackVector | output | 8 | Vector latched by the last hardware acknowledge |

## Verification
Four properties are checked on every cycle. The interrupt output never rises without an unmasked pending request. A valid acknowledge always leaves the winner in service, while a spurious acknowledge leaves the in-service register untouched. Each end-of-interrupt retires exactly one level. The mask changes only on a mask write, and no masked level ever enters service. Only the bench's scenarios can show the rest: the order in which setup words are consumed, what the poll byte and vector contain, that a readback selection persists, that a held input does not latch again, and that ignored commands really have no effect.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_IRQ = 8;
  localparam int LVL_W = $clog2(NUM_IRQ);

  typedef enum logic [1:0] {
    ST_READY,
    ST_BASE,
    ST_CASC,
    ST_MODE
  } setupState_t;

  typedef struct packed {
    logic initStart;
    logic loadBase;
    logic loadMask;
    logic selIrr;
    logic selIsr;
    logic eoi;
    logic ackPoll;
    logic ackHw;
  } ctrlStrb_t;
endpackage

// File: rtl/vec_irq_ctrl_fsm.sv
module vec_irq_ctrl_fsm
  import vec_irq_pkg::*;
#(
  parameter int DataW = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busAddr,
  input  logic             busWe,
  input  logic             busRe,
  input  logic [DataW-1:0] busWrData,
  input  logic             intAck,
  output ctrlStrb_t        strb,
  output logic             pollArmed
);
  setupState_t state;
  logic needCasc, needMode;
  logic evenWr, oddWr, isCmd3;

  assign evenWr = busWe && !busAddr;
  assign oddWr  = busWe && busAddr;
  assign isCmd3 = evenWr && !busWrData[4] && busWrData[3];

  always_comb begin
    strb = '0;
    if (evenWr) begin
      if (busWrData[4]) begin
        strb.initStart = 1'b1;
      end else if (busWrData[3]) begin
        strb.selIrr = (busWrData[1:0] == 2'b10);
        strb.selIsr = (busWrData[1:0] == 2'b11);
      end else if (busWrData[7:5] == 3'b001) begin
        strb.eoi = 1'b1;
      end
    end
    if (oddWr) begin
      strb.loadBase = (state == ST_BASE);
      strb.loadMask = (state == ST_READY);
    end
    strb.ackPoll = busRe && !busAddr && pollArmed;
    strb.ackHw   = intAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_READY;
      needCasc  <= 1'b0;
      needMode  <= 1'b0;
      pollArmed <= 1'b0;
    end else begin
      if (strb.initStart) begin
        state     <= ST_BASE;
        needCasc  <= !busWrData[1];
        needMode  <= busWrData[0];
        pollArmed <= 1'b0;
      end else begin
        if (oddWr) begin
          unique case (state)
            ST_BASE: state <= needCasc ? ST_CASC : (needMode ? ST_MODE : ST_READY);
            ST_CASC: state <= needMode ? ST_MODE : ST_READY;
            ST_MODE: state <= ST_READY;
            default: state <= ST_READY;
          endcase
        end
        if (isCmd3) pollArmed <= busWrData[2];
        else if (strb.ackPoll) pollArmed <= 1'b0;
      end
    end
  end

  AST_MODE_ONLY_IF_ASKED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MODE) |-> needMode); // R3
  AST_POLL_SINGLE_USE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackPoll && !busWe) |=> !pollArmed); // R7
endmodule

// File: rtl/vec_irq_ctrl_dp.sv
module vec_irq_ctrl_dp
  import vec_irq_pkg::*;
#(
  parameter int DataW = DATA_W,
  parameter int NumIrq = NUM_IRQ
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              pollArmed,
  input  logic              busAddr,
  input  logic [DataW-1:0]  busWrData,
  input  logic [NumIrq-1:0] irqIn,
  output logic [DataW-1:0]  busRdData,
  output logic              intOut,
  output logic [DataW-1:0]  ackVector
);
  localparam int LvlW = $clog2(NumIrq);
  localparam int BaseW = DataW - LvlW;

  logic [NumIrq-1:0] irr, isr, mask, irqPrev;
  logic [BaseW-1:0]  vecBase;
  logic              selIsr;

  logic [NumIrq-1:0] req, rise, ackSet, eoiClr;
  logic [LvlW-1:0]   reqLvl, isrLvl, winLvl;
  logic              reqAny, isrAny, winValid, ack;
  logic [DataW-1:0]  pollByte;

  assign req  = irr & ~mask;
  assign rise = irqIn & ~irqPrev;
  assign ack  = strb.ackPoll || strb.ackHw;

  always_comb begin
    reqAny = 1'b0;
    reqLvl = '0;
    isrAny = 1'b0;
    isrLvl = '0;
    for (int i = NumIrq - 1; i >= 0; i--) begin
      if (req[i]) begin
        reqAny = 1'b1;
        reqLvl = LvlW'(i);
      end
      if (isr[i]) begin
        isrAny = 1'b1;
        isrLvl = LvlW'(i);
      end
    end
  end

  assign winValid = reqAny && (!isrAny || (reqLvl < isrLvl));
  assign winLvl   = winValid ? reqLvl : {LvlW{1'b1}};
  assign ackSet   = (ack && winValid) ? (NumIrq'(1) << winLvl) : '0;
  assign eoiClr   = (strb.eoi && isrAny) ? (NumIrq'(1) << isrLvl) : '0;
  assign pollByte = {winValid, {(DataW-LvlW-1){1'b0}}, winLvl};
  assign intOut   = winValid;

  always_comb begin
    if (busAddr)        busRdData = mask;
    else if (pollArmed) busRdData = pollByte;
    else if (selIsr)    busRdData = isr;
    else                busRdData = irr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr       <= '0;
      isr       <= '0;
      mask      <= '1;
      irqPrev   <= '0;
      vecBase   <= '0;
      selIsr    <= 1'b0;
      ackVector <= '0;
    end else begin
      irqPrev <= irqIn;
      if (strb.initStart) begin
        irr    <= '0;
        isr    <= '0;
        selIsr <= 1'b0;
      end else begin
        irr <= (irr & ~ackSet) | rise;
        isr <= (isr & ~eoiClr) | ackSet;
        if (strb.selIsr) selIsr <= 1'b1;
        else if (strb.selIrr) selIsr <= 1'b0;
      end
      if (strb.loadBase) vecBase <= busWrData[DataW-1:LvlW];
      if (strb.loadMask) mask <= busWrData[NumIrq-1:0];
      if (strb.ackHw) ackVector <= {vecBase, winLvl};
    end
  end

  AST_INT_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((irr & ~mask) != '0)); // R6
  AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    (ack && intOut && !strb.initStart) |=> isr[$past(winLvl)]); // R9
  AST_SPURIOUS_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !intOut && !strb.eoi && !strb.initStart) |=> $stable(isr)); // R10
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoi && !ack && !strb.initStart && (isr != '0))
      |=> ($countones(isr) == $countones($past(isr)) - 1)); // R11
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadMask |=> $stable(mask)); // R4
  AST_MASKED_NEVER_SERVED: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> (((isr & ~$past(isr)) & $past(mask)) == '0)); // R12
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int DataW = DATA_W,
  parameter int NumIrq = NUM_IRQ
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DataW-1:0]  busWrData,
  output logic [DataW-1:0]  busRdData,
  input  logic [NumIrq-1:0] irqIn,
  input  logic              intAck,
  output logic              intOut,
  output logic [DataW-1:0]  ackVector
);
  ctrlStrb_t strb;
  logic      pollArmed;

  vec_irq_ctrl_fsm #(.DataW(DataW)) i_fsm (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWrData(busWrData), .intAck(intAck), .strb(strb), .pollArmed(pollArmed)
  );

  vec_irq_ctrl_dp #(.DataW(DataW), .NumIrq(NumIrq)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pollArmed(pollArmed),
    .busAddr(busAddr), .busWrData(busWrData), .irqIn(irqIn),
    .busRdData(busRdData), .intOut(intOut), .ackVector(ackVector)
  );
endmodule

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
  localparam int SRC_RD = 0;
  localparam int SRC_INT = 1;
  localparam int SRC_VEC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busAddr = 1'b0, busWe = 1'b0, busRe = 1'b0, intAck = 1'b0;
  logic [7:0] busWrData = '0, irqIn = '0;
  logic [7:0] busRdData, ackVector;
  logic intOut;

  int compared = 0;
  int mismatched = 0;
  logic sampleReq = 1'b0;
  logic done = 1'b0;

  logic [7:0] expQ[$];
  int srcQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWrData(busWrData), .busRdData(busRdData), .irqIn(irqIn),
    .intAck(intAck), .intOut(intOut), .ackVector(ackVector)
  );

  // Monitor: pops one expected item per requested sample, away from the edge
  always @(negedge clk) begin
    if (sampleReq && expQ.size() > 0) begin
      logic [7:0] want, got;
      int src;
      string tag;
      want = expQ.pop_front();
      src = srcQ.pop_front();
      tag = tagQ.pop_front();
      case (src)
        SRC_RD:  got = busRdData;
        SRC_INT: got = {7'b0, intOut};
        default: got = ackVector;
      endcase
      compared++;
      if (got !== want) begin
        mismatched++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, got, want);
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    busAddr = a; busWrData = d; busWe = 1'b1;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    busAddr = a; busRe = 1'b1;
    expQ.push_back(exp); srcQ.push_back(SRC_RD); tagQ.push_back(tag);
    sampleReq = 1'b1;
    @(posedge clk); #1;
    busRe = 1'b0; sampleReq = 1'b0;
  endtask

  task automatic chk(input int src, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    expQ.push_back(exp); srcQ.push_back(src); tagQ.push_back(tag);
    sampleReq = 1'b1;
    @(posedge clk); #1;
    sampleReq = 1'b0;
  endtask

  task automatic setIrq(input logic [7:0] v);
    @(posedge clk); #1;
    irqIn = v;
    @(posedge clk); #1;
  endtask

  task automatic hwAck();
    @(posedge clk); #1;
    intAck = 1'b1;
    @(posedge clk); #1;
    intAck = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    rd(1'b1, 8'hFF, "R1 mask after reset");
    rd(1'b0, 8'h00, "R1 pending after reset");
    chk(SRC_INT, 8'h00, "R1 intOut after reset");

    // Full setup: start word asks for a mode word, base 0x20
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h01);
    wr(1'b1, 8'h00);
    rd(1'b1, 8'h00, "R3 mask loaded after mode word");

    setIrq(8'h28);
    chk(SRC_INT, 8'h01, "R6 interrupt raised");
    rd(1'b0, 8'h28, "R5 edges latched");

    hwAck();
    chk(SRC_VEC, 8'h23, "R9 vector base|level3");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h08, "R8 in-service readback");
    rd(1'b0, 8'h08, "R8 selection persists");
    chk(SRC_INT, 8'h00, "R6 lower level blocked by service");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h20, "R5 acked bit cleared, held input not relatched");

    // Poll while only a lower level waits: spurious
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h07, "R10 poll with no winner");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h08, "R10 in-service unchanged");

    wr(1'b0, 8'h20);
    rd(1'b0, 8'h00, "R11 end-of-interrupt clears level3");
    chk(SRC_INT, 8'h01, "R6 level5 now wins");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h85, "R7 poll byte level5");
    rd(1'b0, 8'h20, "R7 poll set in-service, back to selected register");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h00, "R7 poll cleared pending");

    wr(1'b0, 8'h60);
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h20, "R11 other command ignored");
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h00, "R11 end-of-interrupt clears level5");

    // Masked input
    wr(1'b1, 8'h01);
    setIrq(8'h29);
    chk(SRC_INT, 8'h00, "R12 masked input silent");
    hwAck();
    chk(SRC_VEC, 8'h27, "R10 spurious vector level7");
    rd(1'b0, 8'h00, "R12 masked level not served");
    rd(1'b1, 8'h01, "R4 mask readback");
    wr(1'b1, 8'h00);
    chk(SRC_INT, 8'h01, "R4 unmask releases request");

    // Short setup: single mode, no mode word
    wr(1'b0, 8'h12);
    rd(1'b0, 8'h00, "R2 setup clears pending");
    wr(1'b1, 8'h0D);
    wr(1'b1, 8'h5A);
    rd(1'b1, 8'h5A, "R3 cascade and mode words skipped");
    wr(1'b1, 8'h00);
    setIrq(8'h00);
    setIrq(8'h80);
    hwAck();
    chk(SRC_VEC, 8'h0F, "R2 base bits 7:3 kept, level7");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h80, "R10 real level7 marked in service");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule